// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt request lines and a processor core. It decides when a pending request may preempt the work that is already running. Each line has an 8-bit urgency value that software writes through a small write port. A smaller value means a more urgent line.

Only the top `PRIO_BITS` bits of each value are compared. Values that share those bits therefore form one preemption group. The controller tracks the current execution priority with a stack of the groups that are now in service. When a handler returns, an exit pulse pops the stack, so interrupted handlers resume at their own level.

A single mask input holds off every take while it is high. Requests that arrive during that time are still recorded.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, no take is signalled, `exec_prio` reads 256, no line is pending, and every line's urgency value is 0. A write with `prio_we` high stores `prio_wdata` for line `prio_idx` on the next clock edge.
- R2: Two lines are compared only on bits [7:8-PRIO_BITS] of their values. With PRIO_BITS=4, the values 32 and 40 count as equal.
- R3: A pending line is taken only when its group is strictly smaller than the current execution group. A pending line in an equal or larger group waits.
- R4: With no handler active, `exec_prio` is 256, and any pending line may be taken.
- R5: While `mask_all` is high, nothing is taken. Pending lines are kept and are taken after `mask_all` drops.
- R6: The active stack holds up to 2^PRIO_BITS nested entries, and each entry restores its own level.
- R7: An `handler_exit` pulse pops one entry. `exec_prio` then returns to the level below it, or to 256 if the stack is empty. An exit with an empty stack changes nothing.
- R8: No take is issued in the cycle whose clock edge processes an exit.
- R9: Among eligible pending lines in the same group, the lowest line index wins.
- R10: A low-to-high change on a request line sets that line's pending bit. A line held high does not set it again. A take clears the winner's pending bit.
- R11: A take is a one-cycle pulse on `take_valid` with the line in `take_line`. In that same cycle, `exec_prio` shows the winner's group as group << (8-PRIO_BITS). Suppose a line rises before clock edge k and is eligible. Its pending bit is then set at edge k, and the take appears at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_LINES | Interrupt request lines, edge sensitive |
| mask_all | input | 1 | Global hold-off of all takes |
| prio_we | input | 1 | Urgency register write strobe |
| prio_idx | input | $clog2(NUM_LINES) | Line whose urgency value is written |
| prio_wdata | input | 8 | New urgency value |
| handler_exit | input | 1 | One-cycle pulse when a handler returns |
| take_valid | output | 1 | One-cycle take pulse |
| take_line | output | $clog2(NUM_LINES) | Index of the taken line |
| exec_prio | output | 9 | Current execution priority, 256 when idle |

## Verification
The bench raises two lines whose values differ but share a group. A design that compared full 8-bit values would let the second line preempt the first, and the scoreboard would see a take it did not expect.

It also lets two same-group lines wait behind a handler and then releases them with exits. A wrong tie-break would take the higher index first, and a missing pop would leave `exec_prio` stuck.

In one cycle it drops the mask and pulses an exit together. A design that arbitrated during the exit cycle would take early. Last, it holds a line high for many cycles. A level-sensitive design would take that line again after its handler exits.

// File: rtl/nic_pkg.sv
package nic_pkg;
  // preemption group of an 8-bit urgency value
  function automatic logic [7:0] prio_group(input logic [7:0] value, input int pb);
    return value >> (8 - pb);
  endfunction

  // external execution priority from an extended group (top bit = idle)
  function automatic logic [8:0] group_to_prio(input logic [8:0] grp, input int pb);
    return grp << (8 - pb);
  endfunction
endpackage

// File: rtl/nic_prio_regs.sv
module nic_prio_regs #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_BITS = 4,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [7:0]                          wdata,
  output logic [NUM_LINES-1:0][PRIO_BITS-1:0] grp
);
  import nic_pkg::*;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_reg
    logic [7:0] value;
    logic [7:0] grp_full;
    always_ff @(posedge clk) begin
      if (!rst_n)                          value <= '0;
      else if (we && idx == IDX_W'(g))     value <= wdata;
    end
    assign grp_full = prio_group(value, PRIO_BITS);
    assign grp[g]   = grp_full[PRIO_BITS-1:0];
  end
endmodule

// File: rtl/nic_pending.sv
module nic_pending #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] pend
);
  logic [NUM_LINES-1:0] irq_q;
  logic [NUM_LINES-1:0] rise;

  assign rise = irq & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0;
      pend  <= '0;
    end else begin
      irq_q <= irq;
      pend  <= (pend & ~clr) | rise;
    end
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_BITS = 4,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]                pend,
  input  logic [NUM_LINES-1:0][PRIO_BITS-1:0] grp,
  input  logic [PRIO_BITS:0]                  exec_grp,
  output logic                                found,
  output logic [IDX_W-1:0]                    win_idx,
  output logic [PRIO_BITS-1:0]                win_grp
);
  logic [PRIO_BITS:0] best;

  // ascending scan with strict compare: lowest index wins a tie,
  // and nothing wins unless strictly below the execution group
  always_comb begin
    best    = exec_grp;
    found   = 1'b0;
    win_idx = '0;
    win_grp = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pend[i] && {1'b0, grp[i]} < best) begin
        best    = {1'b0, grp[i]};
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_grp = grp[i];
      end
    end
  end
endmodule

// File: rtl/nic_stack.sv
module nic_stack #(
  parameter int PRIO_BITS = 4,
  localparam int DEPTH = 1 << PRIO_BITS,
  localparam int SW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic                 pop,
  input  logic [PRIO_BITS-1:0] push_grp,
  output logic [PRIO_BITS:0]   exec_grp,
  output logic [CNT_W-1:0]     depth
);
  logic [PRIO_BITS-1:0] stk [DEPTH];
  logic [CNT_W-1:0]     top_pos;

  assign top_pos  = depth - CNT_W'(1);
  assign exec_grp = (depth == '0) ? {1'b1, {PRIO_BITS{1'b0}}}
                                  : {1'b0, stk[SW'(top_pos)]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push && depth < CNT_W'(DEPTH)) begin
      stk[SW'(depth)] <= push_grp;
      depth           <= depth + CNT_W'(1);
    end else if (pop && depth != '0) begin
      depth <= top_pos;
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_BITS = 4,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int CNT_W = $clog2((1 << PRIO_BITS) + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic                 mask_all,
  input  logic                 prio_we,
  input  logic [IDX_W-1:0]     prio_idx,
  input  logic [7:0]           prio_wdata,
  input  logic                 handler_exit,
  output logic                 take_valid,
  output logic [IDX_W-1:0]     take_line,
  output logic [8:0]           exec_prio
);
  import nic_pkg::*;

  logic [NUM_LINES-1:0][PRIO_BITS-1:0] line_grp;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] clr_vec;
  logic [PRIO_BITS:0]   exec_grp;
  logic [CNT_W-1:0]     stk_depth;
  logic                 found;
  logic [IDX_W-1:0]     win_idx;
  logic [PRIO_BITS-1:0] win_grp;
  // named events for the checker
  logic                 win_ok;
  logic                 do_pop;

  nic_prio_regs #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(prio_we), .idx(prio_idx),
    .wdata(prio_wdata), .grp(line_grp));

  nic_pending #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq(irq_req), .clr(clr_vec), .pend(pend));

  nic_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_arb (
    .pend(pend), .grp(line_grp), .exec_grp(exec_grp),
    .found(found), .win_idx(win_idx), .win_grp(win_grp));

  assign win_ok  = found && !mask_all && !handler_exit;
  assign do_pop  = handler_exit && stk_depth != '0;
  assign clr_vec = win_ok ? (NUM_LINES'(1) << win_idx) : '0;

  nic_stack #(.PRIO_BITS(PRIO_BITS)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(win_ok), .pop(do_pop),
    .push_grp(win_grp), .exec_grp(exec_grp), .depth(stk_depth));

  assign exec_prio = group_to_prio(9'(exec_grp), PRIO_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_valid <= 1'b0;
      take_line  <= '0;
    end else begin
      take_valid <= win_ok;
      take_line  <= win_ok ? win_idx : take_line;
    end
  end
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int PRIO_BITS = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mask_all,
  input logic             handler_exit,
  input logic             take_valid,
  input logic [8:0]       exec_prio,
  input logic [CNT_W-1:0] depth
);
  assert_take_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> !$past(mask_all));

  assert_no_take_on_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(handler_exit) |-> !take_valid);

  assert_strict_preempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> exec_prio < $past(exec_prio));

  assert_exit_pops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(handler_exit) && $past(depth) != '0) |-> depth == $past(depth) - CNT_W'(1));

  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(1 << PRIO_BITS));
endmodule

bind nest_irq_ctrl nic_checker #(.PRIO_BITS(PRIO_BITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_all(mask_all), .handler_exit(handler_exit),
  .take_valid(take_valid), .exec_prio(exec_prio), .depth(stk_depth));

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
  localparam int N = 8;
  localparam int PB = 4;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic mask_all = 1'b0;
  logic prio_we = 1'b0;
  logic [IW-1:0] prio_idx = '0;
  logic [7:0] prio_wdata = '0;
  logic handler_exit = 1'b0;
  logic take_valid;
  logic [IW-1:0] take_line;
  logic [8:0] exec_prio;

  int checks = 0;
  int errors = 0;
  int exp_line[$];
  int exp_prio[$];

  always #5 clk = ~clk;

  nest_irq_ctrl #(.NUM_LINES(N), .PRIO_BITS(PB)) uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_all(mask_all),
    .prio_we(prio_we), .prio_idx(prio_idx), .prio_wdata(prio_wdata),
    .handler_exit(handler_exit), .take_valid(take_valid),
    .take_line(take_line), .exec_prio(exec_prio));

  // model of the grouping rule, written independently
  function automatic int grp_level(input int value);
    return (value / (256 >> PB)) * (256 >> PB);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_take(input int line, input int value);
    exp_line.push_back(line);
    exp_prio.push_back(grp_level(value));
  endtask

  task automatic write_prio(input int line, input int value);
    @(negedge clk);
    prio_we = 1'b1; prio_idx = IW'(line); prio_wdata = 8'(value);
    @(negedge clk);
    prio_we = 1'b0;
  endtask

  task automatic pulse_irq(input int line);
    @(negedge clk); irq_req[line] = 1'b1;
    @(negedge clk); irq_req[line] = 1'b0;
  endtask

  task automatic do_exit();
    @(negedge clk); handler_exit = 1'b1;
    @(negedge clk); handler_exit = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every take must match the head of the scoreboard (R11, R9, R3)
  always @(negedge clk) begin
    if (rst_n && take_valid) begin
      if (exp_line.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3: unexpected take of line %0d at level %0d, expected none",
                 take_line, exec_prio);
      end else begin
        int l, p;
        l = exp_line.pop_front();
        p = exp_prio.pop_front();
        check("R11 take line", int'(take_line), l);
        check("R11 level on take", int'(exec_prio), p);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 take after reset", int'(take_valid), 0);
    check("R1 idle level after reset", int'(exec_prio), 256);
    rst_n = 1'b1;
    idle(2);
    check("R4 idle level", int'(exec_prio), 256);

    // R1: reset value 0 -> level 0; take timing per R11
    @(negedge clk); irq_req[7] = 1'b1;
    expect_take(7, 0);
    @(negedge clk); irq_req[7] = 1'b0;
    check("R11 no take one edge after rise", int'(take_valid), 0);
    @(negedge clk);
    check("R11 take two edges after rise", int'(take_valid), 1);
    @(negedge clk);
    check("R11 take lasts one cycle", int'(take_valid), 0);
    do_exit(); idle(2);
    check("R7 exit to idle", int'(exec_prio), 256);

    write_prio(0, 200); write_prio(1, 48); write_prio(2, 40);
    write_prio(3, 32);  write_prio(4, 32); write_prio(5, 100);
    write_prio(6, 16);  write_prio(7, 20);

    // nesting three deep (R4, R3, R6)
    expect_take(5, 100); pulse_irq(5); idle(4);
    check("R4 first take from idle", int'(exec_prio), 96);
    expect_take(1, 48); pulse_irq(1); idle(4);
    check("R6 second level", int'(exec_prio), 48);
    expect_take(2, 40); pulse_irq(2); idle(4);
    check("R6 third level", int'(exec_prio), 32);
    // 32 shares group with 40: must wait (R2, R3)
    pulse_irq(3); pulse_irq(4); idle(4);
    check("R2 same group waits", int'(exec_prio), 32);
    // exit releases lowest index of the tie first (R9)
    expect_take(3, 32); do_exit(); idle(4);
    check("R9 tie winner nested", int'(exec_prio), 32);
    expect_take(4, 32); do_exit(); idle(4);
    check("R9 second of tie", int'(exec_prio), 32);
    do_exit(); idle(2);
    check("R7 pop to 48", int'(exec_prio), 48);
    do_exit(); idle(2);
    check("R7 pop to 96", int'(exec_prio), 96);
    do_exit(); idle(2);
    check("R7 pop to idle", int'(exec_prio), 256);
    do_exit(); idle(2);
    check("R7 empty exit ignored", int'(exec_prio), 256);

    // R5: mask holds off, pending kept
    @(negedge clk); mask_all = 1'b1;
    pulse_irq(0); idle(4);
    check("R5 masked no take", int'(exec_prio), 256);
    expect_take(0, 200);
    @(negedge clk); mask_all = 1'b0;
    idle(4);
    check("R5 taken after unmask", int'(exec_prio), 192);

    // R8: exit and unmask in the same cycle
    @(negedge clk); mask_all = 1'b1;
    pulse_irq(7); idle(3);
    expect_take(7, 20);
    @(negedge clk); mask_all = 1'b0; handler_exit = 1'b1;
    @(negedge clk); handler_exit = 1'b0;
    check("R8 no take in exit cycle", int'(take_valid), 0);
    check("R8 level after exit", int'(exec_prio), 256);
    @(negedge clk);
    check("R8 take one cycle later", int'(take_valid), 1);
    do_exit(); idle(2);
    check("R7 back to idle", int'(exec_prio), 256);

    // R10: held level takes once only
    expect_take(6, 16);
    @(negedge clk); irq_req[6] = 1'b1;
    idle(10);
    check("R10 held line one take", int'(exec_prio), 16);
    do_exit(); idle(6);
    check("R10 no retake while high", int'(exec_prio), 256);
    @(negedge clk); irq_req[6] = 1'b0;
    idle(3);

    check("R11 scoreboard drained", exp_line.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule